// File: doc/BRIEF.md
# Multi-Mode Memory Address Generator

This unit turns an addressing-mode code and its operands into the effective address of a load or store. It takes a base register value, an index register value, a raw immediate field with a width code, a 2-bit scale shift and the program counter. It returns one address per accepted request. In the two modes that modify the base register, it also returns the updated base value and a one-cycle write-back strobe.

One mode dereferences a pointer. The unit places a read at the base address on a valid/ready memory port, waits for the returned word and hands that word out as the final address. All other modes finish without touching memory. A request is offered with `req_valid` and taken in a cycle where `req_ready` is high. The result appears as a single-cycle pulse on `res_valid`.

Top module: `addr_gen_unit`

## Requirements
- R1: After reset, `res_valid`, `wb_en`, `illegal` and `mem_req_valid` are low and `req_ready` is high.
- R2: Mode 3'd0 (displacement) gives base + sign-extended immediate. Width code `disp_sz` 2'b00 takes `imm_field[7:0]`, 2'b01 takes `imm_field[15:0]`, and 2'b10/2'b11 take all 32 bits.
- R3: Mode 3'd1 (index-base) gives base + index, and the immediate has no effect.
- R4: Mode 3'd2 (scaled) gives base + (index << `scale_sh`) + sign-extended immediate. Shift codes 0..3 mean scale 1, 2, 4 and 8.
- R5: Mode 3'd3 (auto-increment) gives the base unchanged as the address, with `wb_en` high and `wb_data` = base + 1.
- R6: Mode 3'd4 (auto-indexing) gives base + sign-extended immediate as the address, with `wb_en` high and `wb_data` equal to that same sum.
- R7: Mode 3'd6 (PC-relative) gives pc + sign-extended immediate, and the base has no effect.
- R8: Mode 3'd5 (memory-indirect) raises `mem_req_valid` with `mem_req_addr` = base in the cycle after acceptance. It holds both stable until `mem_req_ready`. It keeps `res_valid` low until a `mem_rsp_valid` arrives after that handshake. In the following cycle it outputs the response word as `res_addr`, with no write-back.
- R9: `wb_en` is high for exactly one cycle, only together with `res_valid`, and only in modes 3 and 4.
- R10: Mode 3'd7 is illegal. It gives `res_valid` with `illegal` high, `res_addr` 0 and no write-back, and it issues no memory request.
- R11: Every mode except memory-indirect has its result one cycle after acceptance. `res_valid` lasts one cycle. `req_ready` is low from acceptance until the cycle after the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request |
| mode | input | 3 | Addressing mode code |
| disp_sz | input | 2 | Immediate width code |
| scale_sh | input | 2 | Index shift amount |
| base | input | AW | Base register value |
| index | input | AW | Index register value |
| imm_field | input | 32 | Raw immediate field |
| pc | input | AW | Program counter |
| res_valid | output | 1 | Result pulse |
| res_addr | output | AW | Effective address |
| wb_en | output | 1 | Base write-back strobe |
| wb_data | output | AW | New base value |
| illegal | output | 1 | Mode code not supported |
| mem_req_valid | output | 1 | Pointer read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Pointer read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | AW | Returned pointer word |

## Verification
A wrong sign extension or shift shows as a wrong `res_addr` in the very cycle after acceptance. Each mode is therefore driven with operands whose upper bits differ when the extension or scale is wrong. A lost or stuck state in the indirect sequence shows as a dropped, moved or early `mem_req_valid`, or as a `res_valid` before the response. The bench looks at these every cycle of a stalled handshake and a delayed response. A write-back strobe that lingers or strays into other modes shows on `wb_en` within one cycle of the result.

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    mode,
  input  logic [1:0]    disp_sz,
  input  logic [1:0]    scale_sh,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [31:0]   imm_field,
  input  logic [AW-1:0] pc,
  output logic          res_valid,
  output logic [AW-1:0] res_addr,
  output logic          wb_en,
  output logic [AW-1:0] wb_data,
  output logic          illegal,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data
);

  localparam logic [2:0] MD_DISP = 3'd0, MD_IDX = 3'd1, MD_SCL = 3'd2,
                         MD_AINC = 3'd3, MD_AIDX = 3'd4, MD_IND = 3'd5,
                         MD_PCR = 3'd6;

  typedef enum logic [1:0] {ST_IDLE, ST_MREQ, ST_MWAIT} st_t;
  st_t st;

  logic [AW-1:0] disp, n_addr, n_wbd, ptr_q;
  logic          n_wb, n_ill, take;

  always_comb begin
    case (disp_sz)
      2'b00:   disp = AW'($signed(imm_field[7:0]));
      2'b01:   disp = AW'($signed(imm_field[15:0]));
      default: disp = AW'($signed(imm_field));
    endcase
  end

  always_comb begin
    n_addr = '0;
    n_wbd  = '0;
    n_wb   = 1'b0;
    n_ill  = 1'b0;
    case (mode)
      MD_DISP: n_addr = base + disp;
      MD_IDX:  n_addr = base + index;
      MD_SCL:  n_addr = base + (index << scale_sh) + disp;
      MD_AINC: begin n_addr = base; n_wbd = base + AW'(1); n_wb = 1'b1; end
      MD_AIDX: begin n_addr = base + disp; n_wbd = base + disp; n_wb = 1'b1; end
      MD_PCR:  n_addr = pc + disp;
      MD_IND:  n_addr = '0;
      default: n_ill = 1'b1;
    endcase
  end

  assign req_ready     = (st == ST_IDLE) && !res_valid;
  assign take          = req_valid && req_ready;
  assign mem_req_valid = (st == ST_MREQ);
  assign mem_req_addr  = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ptr_q     <= '0;
      res_valid <= 1'b0;
      res_addr  <= '0;
      wb_en     <= 1'b0;
      wb_data   <= '0;
      illegal   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      wb_en     <= 1'b0;
      illegal   <= 1'b0;
      case (st)
        ST_IDLE: if (take) begin
          if (mode == MD_IND) begin
            ptr_q <= base;
            st    <= ST_MREQ;
          end else begin
            res_valid <= 1'b1;
            res_addr  <= n_addr;
            wb_en     <= n_wb;
            wb_data   <= n_wbd;
            illegal   <= n_ill;
          end
        end
        ST_MREQ: if (mem_req_ready) st <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          res_valid <= 1'b1;
          res_addr  <= mem_rsp_data;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  wb_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> res_valid && !illegal);

  // R9
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en);

  // R10
  illegal_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_req_valid && res_addr == '0);

  // R8
  mreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R8
  ind_no_early_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !res_valid);

  // R11
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R11
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || mem_req_valid) |-> !req_ready);

endmodule

// File: tb/tb_addr_gen_unit.sv
module tb_addr_gen_unit;
  localparam int CLK_P = 10;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [2:0] mode = 0;
  logic [1:0] disp_sz = 0, scale_sh = 0;
  logic [AW-1:0] base = 0, index = 0, pc = 0;
  logic [31:0] imm_field = 0;
  logic res_valid, wb_en, illegal, mem_req_valid;
  logic [AW-1:0] res_addr, wb_data, mem_req_addr;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [AW-1:0] mem_rsp_data = 0;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  addr_gen_unit #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mode(mode), .disp_sz(disp_sz), .scale_sh(scale_sh), .base(base),
    .index(index), .imm_field(imm_field), .pc(pc), .res_valid(res_valid),
    .res_addr(res_addr), .wb_en(wb_en), .wb_data(wb_data), .illegal(illegal),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      failures++;
      $display("FAIL watchdog act=%0d exp=<5000", cyc);
      summary();
    end
  end

  task automatic t_reset();
    @(negedge clk);
    chk("R1 res_valid", res_valid, 0);
    chk("R1 wb_en", wb_en, 0);
    chk("R1 illegal", illegal, 0);
    chk("R1 mem_req_valid", mem_req_valid, 0);
    chk("R1 req_ready", req_ready, 1);
  endtask

  task automatic t_simple(input string tag, input logic [2:0] m, input logic [1:0] sz,
                          input logic [1:0] sh, input logic [31:0] b, input logic [31:0] ix,
                          input logic [31:0] im, input logic [31:0] p,
                          input logic [31:0] exp_addr, input logic exp_wb,
                          input logic [31:0] exp_wbd);
    chk({tag, " ready before"}, req_ready, 1);
    mode = m; disp_sz = sz; scale_sh = sh; base = b; index = ix; imm_field = im; pc = p;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R11 res_valid"}, res_valid, 1);
    chk({tag, " addr"}, res_addr, exp_addr);
    chk({tag, " R9 wb_en"}, wb_en, exp_wb);
    if (exp_wb) chk({tag, " wb_data"}, wb_data, exp_wbd);
    chk({tag, " illegal"}, illegal, 0);
    chk({tag, " R11 busy"}, req_ready, 0);
    @(negedge clk);
    chk({tag, " R11 pulse"}, res_valid, 0);
    chk({tag, " R9 wb one cycle"}, wb_en, 0);
    chk({tag, " R11 ready again"}, req_ready, 1);
  endtask

  task automatic t_indirect();
    mode = 3'd5; base = 32'h0000_4000; imm_field = 32'h55; disp_sz = 0;
    mem_req_ready = 0;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R8 req valid", mem_req_valid, 1);
    chk("R8 req addr", mem_req_addr, 32'h0000_4000);
    chk("R8 no early result", res_valid, 0);
    base = 32'hDEAD_0000;
    @(negedge clk);
    chk("R8 held valid", mem_req_valid, 1);
    chk("R8 held addr", mem_req_addr, 32'h0000_4000);
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    chk("R8 req dropped", mem_req_valid, 0);
    chk("R8 waiting", res_valid, 0);
    chk("R8 busy", req_ready, 0);
    @(negedge clk);
    chk("R8 still waiting", res_valid, 0);
    mem_rsp_valid = 1; mem_rsp_data = 32'hCAFE_0120;
    @(negedge clk);
    mem_rsp_valid = 0;
    chk("R8 result", res_valid, 1);
    chk("R8 final addr", res_addr, 32'hCAFE_0120);
    chk("R8 no wb", wb_en, 0);
    @(negedge clk);
    chk("R8 pulse", res_valid, 0);
    chk("R8 ready", req_ready, 1);
  endtask

  task automatic t_illegal();
    mode = 3'd7; base = 32'h1234; imm_field = 32'h10;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R10 res_valid", res_valid, 1);
    chk("R10 illegal", illegal, 1);
    chk("R10 addr", res_addr, 0);
    chk("R10 wb", wb_en, 0);
    chk("R10 no mem", mem_req_valid, 0);
    @(negedge clk);
    chk("R10 cleared", illegal, 0);
    chk("R10 no mem later", mem_req_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_simple("R2 d8",  3'd0, 2'b00, 0, 32'h1000, 0, 32'h0000_00F0, 0, 32'h0000_0FF0, 0, 0);
    t_simple("R2 d16", 3'd0, 2'b01, 0, 32'h1000, 0, 32'h1234_8000, 0, 32'hFFFF_9000, 0, 0);
    t_simple("R2 d32", 3'd0, 2'b10, 0, 32'h1000, 0, 32'h0001_2345, 0, 32'h0001_3345, 0, 0);
    t_simple("R3 ib",  3'd1, 2'b10, 0, 32'h2000, 32'h34, 32'h7777_0000, 0, 32'h0000_2034, 0, 0);
    t_simple("R4 x8",  3'd2, 2'b00, 2'd3, 32'h100, 32'h3, 32'h0000_00FC, 0, 32'h0000_0114, 0, 0);
    t_simple("R4 x1",  3'd2, 2'b00, 2'd0, 32'h100, 32'h5, 32'h0, 0, 32'h0000_0105, 0, 0);
    t_simple("R4 x4",  3'd2, 2'b01, 2'd2, 32'h0, 32'h10, 32'h0000_0002, 0, 32'h0000_0042, 0, 0);
    t_simple("R5 ainc", 3'd3, 2'b00, 0, 32'h7FFF_FFFF, 0, 32'h40, 0, 32'h7FFF_FFFF, 1, 32'h8000_0000);
    t_simple("R6 aidx", 3'd4, 2'b00, 0, 32'h400, 0, 32'h0000_00F8, 0, 32'h0000_03F8, 1, 32'h0000_03F8);
    t_simple("R7 pcr", 3'd6, 2'b01, 0, 32'h9999_0000, 0, 32'h0000_0010, 32'h8000, 32'h0000_8010, 0, 0);
    t_indirect();
    t_illegal();
    t_simple("R2 after", 3'd0, 2'b00, 0, 32'h20, 0, 32'h1, 0, 32'h21, 0, 0);
    done = 1;
    summary();
  end
endmodule